// File: doc/BRIEF.md
# Role-Configurable Banked RAM with Three Port Classes

This block is a RAM built from a number of equal banks, each 64 bits wide. A per-bank role field places each bank in one of three address spaces, or leaves it unused. The three spaces are an instruction space on a 64-bit port, a system space on a 64-bit port, and a data space. The data space is shared by two 32-bit ports that split it word by word. Within each space, the banks that hold that role are stacked in ascending bank order from offset zero, so every port sees one packed region however the banks are scattered.

The active role word comes from one of two places. One is a boot preset, selected by a small code that is sampled once after reset. The other is a software word, written through a configuration write port together with a select bit. Accesses outside a port's region return zero and raise an error pulse. When both data ports reach the same bank in one cycle, the even-word port wins and the odd-word port is held off. Contents survive a change of roles, so a bank filled through one port can be read through another after it is reassigned.

Top module: `bankmap_top`

## Requirements
- R1: Bank b takes its role from bits [2b+1:2b] of the active word `cfg_active`: 2'b01 system, 2'b10 data, 2'b11 instruction, 2'b00 unused.
- R2: `boot_sel` is captured on the first rising clock edge after reset is released and is ignored afterwards. Preset s works as follows. Banks 0 and 1 are system. Let d = min(s[1:0], NB-2) and i = min(s[3:2], NB-2-d). The next d banks are data, the next i banks are instruction, and the rest are system. Before the capture, preset 0 (all banks system) is active.
- R3: The select bit resets to 0, which chooses the boot preset. A cycle with `cfg_we` high loads `cfg_wsel` into the select bit and `cfg_wword` into the software word. The change shows on `cfg_active` after that clock edge. 1 selects the software word.
- R4: A software word with fewer than two system fields is not loaded, and the old software word stays. The select bit is still written.
- R5: The region of each port is formed by its banks in ascending index order. Port row address a maps to row a mod BW of the (a / BW)-th such bank.
- R6: The instruction and system ports are 64 bits wide, with one write strobe bit per byte. Strobe bit k enables byte k (bits 8k+7:8k).
- R7: Data row k of the data region holds D0 word k in bits [31:0] and D1 word k in bits [63:32]. Even data words go to D0 and odd data words go to D1.
- R8: A read presents its data on the port's rdata on the clock edge after the request. The rdata is zero in any cycle that does not follow an accepted read.
- R9: A request at or beyond the port's region size, including any request to a port with no banks, raises the port's err for exactly the cycle after it and returns zero data. A write in that case changes no bank.
- R10: When D0 and D1 both address the same bank in range, `d1_stall` is high in that cycle and D1 is not served: the D1 rdata in the next cycle is zero. D0 is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel | input | 4 | Boot preset code, sampled once after reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wsel | input | 1 | Select bit to load (1 = software word) |
| cfg_wword | input | 2*NB | Software role word to load |
| cfg_active | output | 2*NB | Role word currently in force |
| i_req | input | 1 | Instruction port request |
| i_we | input | 1 | Instruction port write |
| i_addr | input | AW | Instruction port row address |
| i_wstrb | input | 8 | Instruction port byte strobes |
| i_wdata | input | 64 | Instruction port write data |
| i_rdata | output | 64 | Instruction port read data |
| i_err | output | 1 | Instruction port range error |
| s_req | input | 1 | System port request |
| s_we | input | 1 | System port write |
| s_addr | input | AW | System port row address |
| s_wstrb | input | 8 | System port byte strobes |
| s_wdata | input | 64 | System port write data |
| s_rdata | output | 64 | System port read data |
| s_err | output | 1 | System port range error |
| d0_req | input | 1 | Even data port request |
| d0_we | input | 1 | Even data port write |
| d0_addr | input | AW | Even data port word address |
| d0_wstrb | input | 4 | Even data port byte strobes |
| d0_wdata | input | 32 | Even data port write data |
| d0_rdata | output | 32 | Even data port read data |
| d0_err | output | 1 | Even data port range error |
| d1_req | input | 1 | Odd data port request |
| d1_we | input | 1 | Odd data port write |
| d1_addr | input | AW | Odd data port word address |
| d1_wstrb | input | 4 | Odd data port byte strobes |
| d1_wdata | input | 32 | Odd data port write data |
| d1_rdata | output | 32 | Odd data port read data |
| d1_err | output | 1 | Odd data port range error |
| d1_stall | output | 1 | Odd data port held off by a bank conflict |

## Verification
Read data and error flags are registered, so they are due one clock edge after the request. The bench drives each request just after a falling edge and samples rdata and err at the next falling edge, by which time that one rising edge has passed. `d1_stall` is combinational, so it is sampled in the request cycle itself once the inputs have settled. A role change takes effect on the edge that writes it, and role words are checked at the falling edge after the configuration write. The boot capture is checked two half-cycles after reset is released.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
   typedef enum logic [1:0] {
      ROLE_NONE = 2'b00,
      ROLE_SYS  = 2'b01,
      ROLE_DTC  = 2'b10,
      ROLE_ITC  = 2'b11
   } role_e;

   localparam int BOOT_W  = 4;
   localparam int WIDE_W  = 64;
   localparam int HALF_W  = 32;
   localparam int MIN_SYS = 2;
endpackage

// File: rtl/bankmap_cfg.sv
module bankmap_cfg
   import bankmap_pkg::*;
#(
   parameter int NB = 6,
   localparam int CW = 2*NB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BOOT_W-1:0] boot_sel,
   input  logic              cfg_we,
   input  logic              cfg_wsel,
   input  logic [CW-1:0]     cfg_wword,
   output logic [CW-1:0]     cfg_active
);
   localparam logic [CW-1:0] ALL_SYS = {NB{ROLE_SYS}};

   function automatic logic [CW-1:0] preset(input logic [BOOT_W-1:0] s);
      logic [CW-1:0] w;
      int rest, nd, ni;
      rest = NB - MIN_SYS;
      nd   = (int'(s[1:0]) < rest) ? int'(s[1:0]) : rest;
      ni   = (int'(s[3:2]) < rest - nd) ? int'(s[3:2]) : rest - nd;
      for (int b = 0; b < NB; b++) begin
         if (b >= MIN_SYS && b < MIN_SYS + nd)
            w[2*b +: 2] = ROLE_DTC;
         else if (b >= MIN_SYS + nd && b < MIN_SYS + nd + ni)
            w[2*b +: 2] = ROLE_ITC;
         else
            w[2*b +: 2] = ROLE_SYS;
      end
      return w;
   endfunction

   function automatic int sys_count(input logic [CW-1:0] w);
      int n;
      n = 0;
      for (int b = 0; b < NB; b++)
         if (w[2*b +: 2] == ROLE_SYS) n++;
      return n;
   endfunction

   logic [BOOT_W-1:0] boot_q;
   logic              taken_q;
   logic              sel_q;
   logic [CW-1:0]     sw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q  <= '0;
         taken_q <= 1'b0;
         sel_q   <= 1'b0;
         sw_q    <= ALL_SYS;
      end else begin
         if (!taken_q) begin
            boot_q  <= boot_sel;
            taken_q <= 1'b1;
         end
         if (cfg_we) begin
            sel_q <= cfg_wsel;
            if (sys_count(cfg_wword) >= MIN_SYS) sw_q <= cfg_wword;
         end
      end
   end

   assign cfg_active = sel_q ? sw_q : preset(boot_q);
endmodule

// File: rtl/bankmap_dec.sv
module bankmap_dec
   import bankmap_pkg::*;
#(
   parameter int   NB   = 6,
   parameter int   BW   = 16,
   parameter int   AW   = 7,
   parameter logic [1:0] ROLE = ROLE_SYS,
   localparam int  RW   = $clog2(BW)
) (
   input  logic [2*NB-1:0] cfg,
   input  logic [AW-1:0]   addr,
   output logic [NB-1:0]   hit,
   output logic            inrange,
   output logic [RW-1:0]   row
);
   logic [AW-RW:0] rank;
   logic [AW-RW:0] upper;

   assign upper = {1'b0, addr[AW-1:RW]};
   assign row   = addr[RW-1:0];

   always_comb begin
      rank = '0;
      hit  = '0;
      for (int b = 0; b < NB; b++) begin
         if (cfg[2*b +: 2] == ROLE) begin
            if (rank == upper) hit[b] = 1'b1;
            rank = rank + 1'b1;
         end
      end
   end

   assign inrange = |hit;
endmodule

// File: rtl/bankmap_bank.sv
module bankmap_bank
   import bankmap_pkg::*;
#(
   parameter int  BW = 16,
   localparam int RW = $clog2(BW)
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [RW-1:0]     row,
   input  logic [7:0]        strb,
   input  logic [WIDE_W-1:0] wdata,
   output logic [WIDE_W-1:0] rdata
);
   logic [WIDE_W-1:0] mem [BW];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) begin
            for (int k = 0; k < 8; k++)
               if (strb[k]) mem[row][8*k +: 8] <= wdata[8*k +: 8];
         end else begin
            rdata <= mem[row];
         end
      end
   end
endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
   import bankmap_pkg::*;
#(
   parameter int  NB = 6,
   parameter int  BW = 16,
   localparam int AW = $clog2(NB*BW),
   localparam int CW = 2*NB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BOOT_W-1:0] boot_sel,
   input  logic              cfg_we,
   input  logic              cfg_wsel,
   input  logic [CW-1:0]     cfg_wword,
   output logic [CW-1:0]     cfg_active,
   input  logic              i_req,
   input  logic              i_we,
   input  logic [AW-1:0]     i_addr,
   input  logic [7:0]        i_wstrb,
   input  logic [WIDE_W-1:0] i_wdata,
   output logic [WIDE_W-1:0] i_rdata,
   output logic              i_err,
   input  logic              s_req,
   input  logic              s_we,
   input  logic [AW-1:0]     s_addr,
   input  logic [7:0]        s_wstrb,
   input  logic [WIDE_W-1:0] s_wdata,
   output logic [WIDE_W-1:0] s_rdata,
   output logic              s_err,
   input  logic              d0_req,
   input  logic              d0_we,
   input  logic [AW-1:0]     d0_addr,
   input  logic [3:0]        d0_wstrb,
   input  logic [HALF_W-1:0] d0_wdata,
   output logic [HALF_W-1:0] d0_rdata,
   output logic              d0_err,
   input  logic              d1_req,
   input  logic              d1_we,
   input  logic [AW-1:0]     d1_addr,
   input  logic [3:0]        d1_wstrb,
   input  logic [HALF_W-1:0] d1_wdata,
   output logic [HALF_W-1:0] d1_rdata,
   output logic              d1_err,
   output logic              d1_stall
);
   localparam int RW = $clog2(BW);

   if (NB < MIN_SYS) begin : g_nb_chk
      $error("bankmap_top: NB must be at least MIN_SYS");
   end
   if (BW < 2 || (BW & (BW - 1)) != 0) begin : g_bw_chk
      $error("bankmap_top: BW must be a power of two of at least 2");
   end

   bankmap_cfg #(.NB(NB)) u_cfg (
      .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel),
      .cfg_we(cfg_we), .cfg_wsel(cfg_wsel), .cfg_wword(cfg_wword),
      .cfg_active(cfg_active)
   );

   logic [NB-1:0] i_hit, s_hit, d0_hit, d1_hit;
   logic          i_inr, s_inr, d0_inr, d1_inr;
   logic [RW-1:0] i_row, s_row, d0_row, d1_row;

   bankmap_dec #(.NB(NB), .BW(BW), .AW(AW), .ROLE(ROLE_ITC)) u_dec_i (
      .cfg(cfg_active), .addr(i_addr), .hit(i_hit), .inrange(i_inr), .row(i_row));
   bankmap_dec #(.NB(NB), .BW(BW), .AW(AW), .ROLE(ROLE_SYS)) u_dec_s (
      .cfg(cfg_active), .addr(s_addr), .hit(s_hit), .inrange(s_inr), .row(s_row));
   bankmap_dec #(.NB(NB), .BW(BW), .AW(AW), .ROLE(ROLE_DTC)) u_dec_d0 (
      .cfg(cfg_active), .addr(d0_addr), .hit(d0_hit), .inrange(d0_inr), .row(d0_row));
   bankmap_dec #(.NB(NB), .BW(BW), .AW(AW), .ROLE(ROLE_DTC)) u_dec_d1 (
      .cfg(cfg_active), .addr(d1_addr), .hit(d1_hit), .inrange(d1_inr), .row(d1_row));

   logic i_go, s_go, d0_go, d1_go;
   assign i_go     = i_req & i_inr;
   assign s_go     = s_req & s_inr;
   assign d0_go    = d0_req & d0_inr;
   assign d1_stall = d0_go & d1_req & d1_inr & |(d0_hit & d1_hit);
   assign d1_go    = d1_req & d1_inr & ~d1_stall;

   logic [WIDE_W-1:0] bank_rd [NB];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic              en, we;
      logic [RW-1:0]     row;
      logic [7:0]        strb;
      logic [WIDE_W-1:0] wd;

      always_comb begin
         en = 1'b0; we = 1'b0; row = '0; strb = '0; wd = '0;
         if (s_go && s_hit[b]) begin
            en = 1'b1; we = s_we; row = s_row; strb = s_wstrb; wd = s_wdata;
         end else if (i_go && i_hit[b]) begin
            en = 1'b1; we = i_we; row = i_row; strb = i_wstrb; wd = i_wdata;
         end else if (d0_go && d0_hit[b]) begin
            en = 1'b1; we = d0_we; row = d0_row;
            strb = {4'b0000, d0_wstrb}; wd = {{HALF_W{1'b0}}, d0_wdata};
         end else if (d1_go && d1_hit[b]) begin
            en = 1'b1; we = d1_we; row = d1_row;
            strb = {d1_wstrb, 4'b0000}; wd = {d1_wdata, {HALF_W{1'b0}}};
         end
      end

      bankmap_bank #(.BW(BW)) u_bank (
         .clk(clk), .en(en), .we(we), .row(row), .strb(strb),
         .wdata(wd), .rdata(bank_rd[b]));
   end

   logic [NB-1:0] i_rsel, s_rsel, d0_rsel, d1_rsel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i_rsel <= '0; s_rsel <= '0; d0_rsel <= '0; d1_rsel <= '0;
         i_err  <= 1'b0; s_err <= 1'b0; d0_err <= 1'b0; d1_err <= 1'b0;
      end else begin
         i_rsel  <= i_hit  & {NB{i_go  & ~i_we}};
         s_rsel  <= s_hit  & {NB{s_go  & ~s_we}};
         d0_rsel <= d0_hit & {NB{d0_go & ~d0_we}};
         d1_rsel <= d1_hit & {NB{d1_go & ~d1_we}};
         i_err   <= i_req  & ~i_inr;
         s_err   <= s_req  & ~s_inr;
         d0_err  <= d0_req & ~d0_inr;
         d1_err  <= d1_req & ~d1_inr;
      end
   end

   always_comb begin
      i_rdata = '0; s_rdata = '0; d0_rdata = '0; d1_rdata = '0;
      for (int b = 0; b < NB; b++) begin
         if (i_rsel[b])  i_rdata  = i_rdata  | bank_rd[b];
         if (s_rsel[b])  s_rdata  = s_rdata  | bank_rd[b];
         if (d0_rsel[b]) d0_rdata = d0_rdata | bank_rd[b][HALF_W-1:0];
         if (d1_rsel[b]) d1_rdata = d1_rdata | bank_rd[b][WIDE_W-1:HALF_W];
      end
   end
endmodule

// File: rtl/bankmap_chk.sv
module bankmap_chk
   import bankmap_pkg::*;
#(
   parameter int NB = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [2*NB-1:0]   cfg_active,
   input logic              i_req,
   input logic              i_we,
   input logic [WIDE_W-1:0] i_rdata,
   input logic              i_err,
   input logic              s_req,
   input logic              s_we,
   input logic [WIDE_W-1:0] s_rdata,
   input logic              s_err,
   input logic              d1_req,
   input logic [HALF_W-1:0] d1_rdata,
   input logic              d1_stall
);
   function automatic int sys_fields(input logic [2*NB-1:0] w);
      int n;
      n = 0;
      for (int b = 0; b < NB; b++)
         if (w[2*b +: 2] == ROLE_SYS) n++;
      return n;
   endfunction

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R4
   min_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_fields(cfg_active) >= MIN_SYS);

   // R3
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !$past(cfg_we)) |-> $stable(cfg_active));

   // R9
   i_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      i_err |-> ($past(i_req) && i_rdata == '0));

   // R9
   s_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_err |-> ($past(s_req) && s_rdata == '0));

   // R8
   s_rdata_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rdata != '0) |-> $past(s_req && !s_we));

   // R8
   i_rdata_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (i_rdata != '0) |-> $past(i_req && !i_we));

   // R10
   d1_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d1_stall && d1_req) |=> (d1_rdata == '0));
endmodule

bind bankmap_top bankmap_chk #(.NB(NB)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_active(cfg_active),
   .i_req(i_req), .i_we(i_we), .i_rdata(i_rdata), .i_err(i_err),
   .s_req(s_req), .s_we(s_we), .s_rdata(s_rdata), .s_err(s_err),
   .d1_req(d1_req), .d1_rdata(d1_rdata), .d1_stall(d1_stall)
);

// File: tb/bankmap_top_test.sv
module bankmap_top_test;
   localparam int NB = 6;
   localparam int AW = 7;
   localparam int CW = 12;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n;
   logic [3:0] boot_sel;
   logic cfg_we, cfg_wsel;
   logic [CW-1:0] cfg_wword, cfg_active;
   logic i_req, i_we, s_req, s_we, d0_req, d0_we, d1_req, d1_we;
   logic [AW-1:0] i_addr, s_addr, d0_addr, d1_addr;
   logic [7:0] i_wstrb, s_wstrb;
   logic [3:0] d0_wstrb, d1_wstrb;
   logic [63:0] i_wdata, s_wdata, i_rdata, s_rdata;
   logic [31:0] d0_wdata, d1_wdata, d0_rdata, d1_rdata;
   logic i_err, s_err, d0_err, d1_err, d1_stall;

   bankmap_top uut (.*);

   int total = 0;
   int bad = 0;
   bit done = 0;

   typedef struct packed {
      logic [1:0]  p;
      logic        we;
      logic [6:0]  a;
      logic [63:0] d;
      logic [63:0] e;
      logic        er;
   } vec_t;

   // preset 5: S = banks 0,1,4,5 ; D = bank 2 ; I = bank 3
   localparam vec_t VEC [14] = '{
      '{2'd1, 1'b1, 7'd0,  64'h1111_2222_3333_4444, 64'h0, 1'b0},
      '{2'd1, 1'b0, 7'd0,  64'h0, 64'h1111_2222_3333_4444, 1'b0},
      '{2'd1, 1'b1, 7'd40, 64'hA5A5_0101_BEEF_7777, 64'h0, 1'b0},
      '{2'd1, 1'b0, 7'd40, 64'h0, 64'hA5A5_0101_BEEF_7777, 1'b0},
      '{2'd1, 1'b1, 7'd64, 64'hDEAD_DEAD_DEAD_DEAD, 64'h0, 1'b1},
      '{2'd1, 1'b0, 7'd64, 64'h0, 64'h0, 1'b1},
      '{2'd1, 1'b0, 7'd0,  64'h0, 64'h1111_2222_3333_4444, 1'b0},
      '{2'd0, 1'b1, 7'd0,  64'h0BAD_F00D_0000_0001, 64'h0, 1'b0},
      '{2'd0, 1'b1, 7'd16, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1},
      '{2'd0, 1'b0, 7'd0,  64'h0, 64'h0BAD_F00D_0000_0001, 1'b0},
      '{2'd2, 1'b1, 7'd3,  64'hCAFE_F00D, 64'h0, 1'b0},
      '{2'd3, 1'b1, 7'd3,  64'h1234_5678, 64'h0, 1'b0},
      '{2'd2, 1'b0, 7'd3,  64'h0, 64'hCAFE_F00D, 1'b0},
      '{2'd3, 1'b0, 7'd3,  64'h0, 64'h1234_5678, 1'b0}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      i_req = 0; s_req = 0; d0_req = 0; d1_req = 0; cfg_we = 0;
   endtask

   // drive one request after a falling edge, sample at the next falling edge
   task automatic access(input logic [1:0] p, input logic we, input logic [6:0] a,
                         input logic [63:0] d, input logic [7:0] strb,
                         output logic [63:0] rd, output logic er);
      @(negedge clk);
      case (p)
         2'd0: begin i_req = 1; i_we = we; i_addr = a; i_wdata = d; i_wstrb = strb; end
         2'd1: begin s_req = 1; s_we = we; s_addr = a; s_wdata = d; s_wstrb = strb; end
         2'd2: begin d0_req = 1; d0_we = we; d0_addr = a; d0_wdata = d[31:0]; d0_wstrb = strb[3:0]; end
         default: begin d1_req = 1; d1_we = we; d1_addr = a; d1_wdata = d[31:0]; d1_wstrb = strb[3:0]; end
      endcase
      @(negedge clk);
      idle();
      case (p)
         2'd0: begin rd = i_rdata; er = i_err; end
         2'd1: begin rd = s_rdata; er = s_err; end
         2'd2: begin rd = {32'h0, d0_rdata}; er = d0_err; end
         default: begin rd = {32'h0, d1_rdata}; er = d1_err; end
      endcase
   endtask

   task automatic cfg_write(input logic sel, input logic [CW-1:0] w);
      @(negedge clk);
      cfg_we = 1; cfg_wsel = sel; cfg_wword = w;
      @(negedge clk);
      cfg_we = 0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] rd;
      logic er;
      rst_n = 0; boot_sel = 4'd5; cfg_wsel = 0; cfg_wword = '0;
      i_we = 0; s_we = 0; d0_we = 0; d1_we = 0;
      i_addr = 0; s_addr = 0; d0_addr = 0; d1_addr = 0;
      i_wstrb = 0; s_wstrb = 0; d0_wstrb = 0; d1_wstrb = 0;
      i_wdata = 0; s_wdata = 0; d0_wdata = 0; d1_wdata = 0;
      idle();
      repeat (3) @(negedge clk);
      // R2 before capture: preset 0, all system; R8 no read data
      check("R2 reset word", {52'h0, cfg_active}, 64'h555);
      check("R8 reset rdata", s_rdata | i_rdata, 64'h0);
      check("R9 reset err", {60'h0, i_err, s_err, d0_err, d1_err}, 64'h0);
      rst_n = 1;
      @(negedge clk);
      // R2/R1 preset 5 = D bank2, I bank3 -> 0x5E5
      check("R2 boot capture", {52'h0, cfg_active}, 64'h5E5);
      boot_sel = 4'd0;
      repeat (3) @(negedge clk);
      check("R2 boot later ignored", {52'h0, cfg_active}, 64'h5E5);

      for (int n = 0; n < 14; n++) begin
         access(VEC[n].p, VEC[n].we, VEC[n].a, VEC[n].d, 8'hFF, rd, er);
         check($sformatf("R5/R6/R7/R9 vec%0d data", n), rd, VEC[n].e);
         check($sformatf("R9 vec%0d err", n), {63'h0, er}, {63'h0, VEC[n].er});
      end

      // R6 byte strobes on the system port
      access(2'd1, 1'b1, 7'd1, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, rd, er);
      check("R8 rdata zero after write", rd, 64'h0);
      access(2'd1, 1'b1, 7'd1, 64'h0, 8'h0F, rd, er);
      access(2'd1, 1'b0, 7'd1, 64'h0, 8'h00, rd, er);
      check("R6 strobe low bytes", rd, 64'hFFFF_FFFF_0000_0000);

      // R3/R5 bank4 becomes instruction: I = banks 3,4 -> I addr 24 = bank4 row8
      cfg_write(1'b1, 12'h7E5);
      check("R3 sw word active", {52'h0, cfg_active}, 64'h7E5);
      access(2'd0, 1'b0, 7'd24, 64'h0, 8'h00, rd, er);
      check("R5 stacked instruction", rd, 64'hA5A5_0101_BEEF_7777);

      // R7 bank0 becomes data: D = banks 0,2
      cfg_write(1'b1, 12'h5E6);
      access(2'd2, 1'b0, 7'd0, 64'h0, 8'h00, rd, er);
      check("R7 D0 low half", rd, 64'h3333_4444);
      access(2'd3, 1'b0, 7'd0, 64'h0, 8'h00, rd, er);
      check("R7 D1 high half", rd, 64'h1111_2222);
      access(2'd2, 1'b0, 7'd19, 64'h0, 8'h00, rd, er);
      check("R5 data second bank", rd, 64'hCAFE_F00D);

      // R4 illegal word: only bank0 system
      cfg_write(1'b1, 12'hAA9);
      check("R4 illegal word ignored", {52'h0, cfg_active}, 64'h5E6);

      // R10 conflict on bank0
      @(negedge clk);
      d0_req = 1; d0_we = 0; d0_addr = 7'd0;
      d1_req = 1; d1_we = 0; d1_addr = 7'd0;
      #1;
      check("R10 stall raised", {63'h0, d1_stall}, 64'h1);
      @(negedge clk);
      check("R10 D0 served", {32'h0, d0_rdata}, 64'h3333_4444);
      check("R10 D1 not served", {32'h0, d1_rdata}, 64'h0);
      d0_req = 0;
      #1;
      check("R10 stall released", {63'h0, d1_stall}, 64'h0);
      @(negedge clk);
      check("R10 D1 after stall", {32'h0, d1_rdata}, 64'h1111_2222);
      // no conflict: different banks
      d0_req = 1; d0_addr = 7'd0; d1_addr = 7'd19;
      #1;
      check("R10 no stall", {63'h0, d1_stall}, 64'h0);
      @(negedge clk);
      idle();
      check("R10 parallel D1", {32'h0, d1_rdata}, 64'h1234_5678);

      // R3 select back to boot preset
      cfg_write(1'b0, 12'h555);
      check("R3 select boot", {52'h0, cfg_active}, 64'h5E5);
      // R9 port with no banks: preset 0 after software all-system, select 1
      cfg_write(1'b1, 12'h555);
      access(2'd0, 1'b0, 7'd0, 64'h0, 8'h00, rd, er);
      check("R9 empty port err", {63'h0, er}, 64'h1);
      check("R9 empty port data", rd, 64'h0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule